// File: doc/BRIEF.md
# Packed Instruction Block Sequencer

This block holds a small program of packed words and hands it out one opcode at a time. Each word holds a 2-bit routing tag and seven 4-bit opcode slots. While the run input is high, the sequencer walks through the slots of the current word, then moves to the next word. After the last word it wraps back to the first. Each opcode goes to the instruction decoder, except for the first slot of a word. The routing tag of that word can send its first slot onto the data bus as a literal value, or to a set of special output pins.

All three issue outputs are valid/ready streams. The opcode under the cursor is offered on exactly one of them. The cursor advances only on a handshake, so a destination that holds its ready low stalls the whole sequence, and the offered value stays stable. Dropping run withdraws the offer without moving the cursor.

The program is written through a load stream. That stream accepts a word only while run is low. Every accepted load sends the cursor back to the first slot of word 0, so a freshly written program always starts from its beginning.

Top module: `pibs_sequencer`

## Requirements
- R1: After reset the program store holds all zeros and the cursor is at word 0, slot 0. Raising run therefore first offers opcode 0 on the decoder stream.
- R2: A program word is laid out as follows. Bits [29:28] hold the routing tag. Slot k (k = 0..6) sits in bits [27-4k : 24-4k]. Slots are issued in the order k = 0, 1, …, 6.
- R3: When the routing tag is 00 or 11, slot 0 is offered on the decoder stream (dec_valid_o high, dec_op_o = slot value).
- R4: When the routing tag is 01, slot 0 is offered on the bus stream (bus_valid_o high, bus_val_o = slot value) and dec_valid_o stays low.
- R5: When the routing tag is 10, slot 0 is offered on the pin stream (pin_valid_o high, pin_val_o = slot value) and dec_valid_o stays low.
- R6: Slots 1 to 6 always go to the decoder stream, whatever the tag.
- R7: At most one of the three valid outputs is high at any time. All three are low while run_i is low.
- R8: While the selected stream has valid high and ready low, the cursor holds and the offered value stays stable. An offer advances by one slot only on a handshake.
- R9: After slot 6 the cursor moves to slot 0 of the next word. After slot 6 of word 13 it wraps to word 0.
- R10: ld_ready_o is high exactly when run_i is low. An accepted load whose address is 0 to 13 replaces that word. A load offered while run is high leaves the program unchanged, and so does an accepted load with address 14 or 15.
- R11: Every accepted load, whatever its address, returns the cursor to word 0, slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Enables issuing; low withdraws offers and opens loading |
| ld_valid_i | input | 1 | Load stream valid |
| ld_ready_o | output | 1 | Load stream ready (high while not running) |
| ld_addr_i | input | 4 | Word index to write |
| ld_word_i | input | 30 | Packed word to write |
| dec_valid_o | output | 1 | Decoder stream valid |
| dec_ready_i | input | 1 | Decoder stream ready |
| dec_op_o | output | 4 | Opcode for the decoder |
| bus_valid_o | output | 1 | Data-bus literal stream valid |
| bus_ready_i | input | 1 | Data-bus literal stream ready |
| bus_val_o | output | 4 | Literal value for the data bus |
| pin_valid_o | output | 1 | Special-pin stream valid |
| pin_ready_i | input | 1 | Special-pin stream ready |
| pin_val_o | output | 4 | Value for the special pins |

## Verification
The bench builds the block with its default parameters: 14 words of seven 4-bit slots. At that size every slot of the program can be filled with a value computed from its word and slot index, and the routing tags cycle through all four codes. Two full passes of 98 issues each then cover every slot, every tag and the wrap from word 13 back to word 0. Stalls on the decoder and bus streams are checked separately. So are loads offered while running, a load to an address past the end, and the cursor restart that a load causes.

// File: rtl/pibs_pkg.sv
package pibs_pkg;

  typedef enum logic [1:0] {
    TAG_DECODE = 2'b00,
    TAG_BUS    = 2'b01,
    TAG_PINS   = 2'b10,
    TAG_SPARE  = 2'b11
  } route_tag_e;

  typedef enum logic [1:0] {
    DST_DEC = 2'd0,
    DST_BUS = 2'd1,
    DST_PIN = 2'd2
  } dest_e;

  // Only the leading slot of a word obeys the tag; the spare code decodes.
  function automatic dest_e pick_dest(input logic lead_slot, input route_tag_e tag);
    dest_e d;
    d = DST_DEC;
    if (lead_slot) begin
      unique case (tag)
        TAG_BUS:  d = DST_BUS;
        TAG_PINS: d = DST_PIN;
        default:  d = DST_DEC;
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/pibs_store.sv
module pibs_store #(
  parameter int WORDS  = 14,
  parameter int WORD_W = 30,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] mem_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem_q[w] <= '0;
      else if (hit)
        mem_q[w] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int w = 0; w < WORDS; w++)
      if (rd_addr == ADDR_W'(w))
        rd_data = mem_q[w];
  end

  // R10: a write never lands outside the program range
  a_r10_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < WORDS));

endmodule

// File: rtl/pibs_cursor.sv
module pibs_cursor #(
  parameter int WORDS  = 14,
  parameter int SLOTS  = 7,
  parameter int ADDR_W = 4,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              advance,
  output logic [ADDR_W-1:0] word_idx,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              lead_slot
);

  localparam logic [ADDR_W-1:0] WORD_LAST = ADDR_W'(WORDS - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

  logic [ADDR_W-1:0] word_q;
  logic [SLOT_W-1:0] slot_q;
  logic              end_of_word;
  logic              end_of_prog;

  assign end_of_word = (slot_q == SLOT_LAST);
  assign end_of_prog = end_of_word && (word_q == WORD_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      slot_q <= '0;
    end else if (restart) begin
      word_q <= '0;
      slot_q <= '0;
    end else if (advance) begin
      if (end_of_word) begin
        slot_q <= '0;
        word_q <= end_of_prog ? '0 : word_q + 1'b1;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  assign word_idx  = word_q;
  assign slot_idx  = slot_q;
  assign lead_slot = (slot_q == '0);

  // R9: the program wraps to its first slot after the final one
  a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !restart && word_idx == WORD_LAST && slot_idx == SLOT_LAST)
      |=> (word_idx == '0 && slot_idx == '0));

  // R9: finishing a word steps to slot 0 of the next word
  a_r9_next_word: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !restart && word_idx != WORD_LAST && slot_idx == SLOT_LAST)
      |=> (slot_idx == '0 && word_idx == $past(word_idx) + 1'b1));

  // R11: a restart always lands on the first slot of word 0
  a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (word_idx == '0 && slot_idx == '0));

  // R2: the slot index never leaves its range
  a_r2_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(slot_idx) < SLOTS);

endmodule

// File: rtl/pibs_router.sv
module pibs_router
  import pibs_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            lead_slot,
  input  logic [1:0]      tag,
  input  logic [OP_W-1:0] op,
  input  logic            dec_ready,
  input  logic            bus_ready,
  input  logic            pin_ready,
  output logic            dec_valid,
  output logic            bus_valid,
  output logic            pin_valid,
  output logic [OP_W-1:0] dec_op,
  output logic [OP_W-1:0] bus_val,
  output logic [OP_W-1:0] pin_val,
  output logic            fire
);

  dest_e dst;

  assign dst = pick_dest(lead_slot, route_tag_e'(tag));

  assign dec_valid = run && (dst == DST_DEC);
  assign bus_valid = run && (dst == DST_BUS);
  assign pin_valid = run && (dst == DST_PIN);

  assign dec_op  = op;
  assign bus_val = op;
  assign pin_val = op;

  assign fire = (dec_valid && dec_ready) ||
                (bus_valid && bus_ready) ||
                (pin_valid && pin_ready);

  // R7: exactly one destination at a time, none when idle
  a_r7_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dec_valid, bus_valid, pin_valid}));

  // R6: trailing slots never leave the decoder path
  a_r6_trailing: assert property (@(posedge clk) disable iff (!rst_n)
    !lead_slot |-> (!bus_valid && !pin_valid));

endmodule

// File: rtl/pibs_sequencer.sv
module pibs_sequencer #(
  parameter int WORDS = 14,
  parameter int SLOTS = 7,
  parameter int OP_W  = 4,
  parameter int TAG_W = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          run_i,
  input  logic                          ld_valid_i,
  output logic                          ld_ready_o,
  input  logic [$clog2(WORDS)-1:0]      ld_addr_i,
  input  logic [SLOTS*OP_W+TAG_W-1:0]   ld_word_i,
  output logic                          dec_valid_o,
  input  logic                          dec_ready_i,
  output logic [OP_W-1:0]               dec_op_o,
  output logic                          bus_valid_o,
  input  logic                          bus_ready_i,
  output logic [OP_W-1:0]               bus_val_o,
  output logic                          pin_valid_o,
  input  logic                          pin_ready_i,
  output logic [OP_W-1:0]               pin_val_o
);

  localparam int ADDR_W  = $clog2(WORDS);
  localparam int SLOT_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int OPS_W   = SLOTS * OP_W;
  localparam int WORD_W  = OPS_W + TAG_W;

  logic              ld_fire;
  logic              wr_en;
  logic [WORD_W-1:0] cur_word;
  logic [ADDR_W-1:0] word_idx;
  logic [SLOT_W-1:0] slot_idx;
  logic              lead_slot;
  logic              fire;
  logic [OP_W-1:0]   slot_ops [SLOTS];
  logic [OP_W-1:0]   cur_op;
  logic [TAG_W-1:0]  cur_tag;

  assign ld_ready_o = !run_i;
  assign ld_fire    = ld_valid_i && ld_ready_o;
  assign wr_en      = ld_fire && (int'(ld_addr_i) < WORDS);

  pibs_store #(.WORDS(WORDS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (ld_addr_i),
    .wr_data (ld_word_i),
    .rd_addr (word_idx),
    .rd_data (cur_word)
  );

  pibs_cursor #(.WORDS(WORDS), .SLOTS(SLOTS), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) i_cursor (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (ld_fire),
    .advance   (fire),
    .word_idx  (word_idx),
    .slot_idx  (slot_idx),
    .lead_slot (lead_slot)
  );

  // Slot 0 sits just below the tag; later slots step toward bit 0.
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign slot_ops[k] = cur_word[OPS_W-1-k*OP_W -: OP_W];
  end

  always_comb begin
    cur_op = slot_ops[0];
    for (int k = 0; k < SLOTS; k++)
      if (slot_idx == SLOT_W'(k))
        cur_op = slot_ops[k];
  end

  assign cur_tag = cur_word[WORD_W-1 -: TAG_W];

  pibs_router #(.OP_W(OP_W)) i_router (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_i),
    .lead_slot (lead_slot),
    .tag       (cur_tag),
    .op        (cur_op),
    .dec_ready (dec_ready_i),
    .bus_ready (bus_ready_i),
    .pin_ready (pin_ready_i),
    .dec_valid (dec_valid_o),
    .bus_valid (bus_valid_o),
    .pin_valid (pin_valid_o),
    .dec_op    (dec_op_o),
    .bus_val   (bus_val_o),
    .pin_val   (pin_val_o),
    .fire      (fire)
  );

  // R8: a stalled decoder offer keeps its value
  a_r8_dec_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_o && !dec_ready_i && !ld_valid_i) |=> $stable(dec_op_o));

  // R8: a stalled bus offer keeps its value
  a_r8_bus_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_o && !bus_ready_i && !ld_valid_i) |=> $stable(bus_val_o));

  // R8: a stalled pin offer keeps its value
  a_r8_pin_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_valid_o && !pin_ready_i && !ld_valid_i) |=> $stable(pin_val_o));

  // R7: nothing is offered while run is low
  a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !(dec_valid_o || bus_valid_o || pin_valid_o));

  // R10: loads and issues never overlap
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ready_o |-> !(dec_valid_o || bus_valid_o || pin_valid_o));

endmodule

// File: tb/test_pibs_sequencer.sv
`timescale 1ns/1ps
module test_pibs_sequencer;

  localparam int WORDS = 14;
  localparam int SLOTS = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [3:0]  ld_addr = '0;
  logic [29:0] ld_word = '0;
  logic        dec_valid, bus_valid, pin_valid;
  logic        dec_ready = 1'b1, bus_ready = 1'b1, pin_ready = 1'b1;
  logic [3:0]  dec_op, bus_val, pin_val;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pibs_sequencer i_pibs_sequencer (
    .clk(clk), .rst_n(rst_n), .run_i(run),
    .ld_valid_i(ld_valid), .ld_ready_o(ld_ready),
    .ld_addr_i(ld_addr), .ld_word_i(ld_word),
    .dec_valid_o(dec_valid), .dec_ready_i(dec_ready), .dec_op_o(dec_op),
    .bus_valid_o(bus_valid), .bus_ready_i(bus_ready), .bus_val_o(bus_val),
    .pin_valid_o(pin_valid), .pin_ready_i(pin_ready), .pin_val_o(pin_val)
  );

  function automatic int exp_op(input int w, input int k);
    return (w * 7 + k + 3) % 16;
  endfunction

  function automatic int exp_tag(input int w);
    return w % 4;
  endfunction

  function automatic logic [29:0] make_word(input int w);
    logic [29:0] d;
    d = '0;
    d[29:28] = 2'(exp_tag(w));
    for (int k = 0; k < SLOTS; k++)
      d[27-4*k -: 4] = 4'(exp_op(w, k));
    return d;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected destination: 0 decoder, 1 bus, 2 pins (R2..R6)
  task automatic check_issue(input int n);
    int w, k, t, d;
    string req;
    w = (n / SLOTS) % WORDS;
    k = n % SLOTS;
    t = exp_tag(w);
    d = 0;
    req = "R3";
    if (k != 0) req = "R6";
    else if (t == 1) begin d = 1; req = "R4"; end
    else if (t == 2) begin d = 2; req = "R5"; end
    check(dec_valid == (d == 0), req, dec_valid, d == 0);
    check(bus_valid == (d == 1), req, bus_valid, d == 1);
    check(pin_valid == (d == 2), req, pin_valid, d == 2);
    if (d == 0) check(dec_op == 4'(exp_op(w, k)), "R2", dec_op, exp_op(w, k));
    if (d == 1) check(bus_val == 4'(exp_op(w, k)), "R2", bus_val, exp_op(w, k));
    if (d == 2) check(pin_val == 4'(exp_op(w, k)), "R2", pin_val, exp_op(w, k));
  endtask

  task automatic load(input int a, input logic [29:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = 4'(a); ld_word = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  // Starts at a negedge with the cursor at issue `first`
  task automatic run_issues(input int first, input int count);
    run = 1'b1;
    for (int i = 0; i < count; i++) begin
      #1 check_issue(first + i);
      @(negedge clk);
    end
    run = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: empty program after reset, cursor at word 0 slot 0
    check(ld_ready == 1'b1, "R10", ld_ready, 1);
    check(!dec_valid && !bus_valid && !pin_valid, "R7", dec_valid, 0);
    run = 1'b1;
    #1;
    check(dec_valid == 1'b1, "R1", dec_valid, 1);
    check(dec_op == 4'd0, "R1", dec_op, 0);
    check(ld_ready == 1'b0, "R10", ld_ready, 0);
    run = 1'b0;

    // Fill the whole program, then sweep two full passes (R2..R6, R9, R11)
    for (int w = 0; w < WORDS; w++) load(w, make_word(w));
    run_issues(0, 2 * WORDS * SLOTS);
    #1;
    check(!dec_valid && !bus_valid && !pin_valid, "R7", dec_valid, 0);

    // Decoder stall holds slot 0 of word 0 (R8)
    load(0, make_word(0));
    dec_ready = 1'b0;
    run = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1 check_issue(0);
      check(dec_op == 4'(exp_op(0, 0)), "R8", dec_op, exp_op(0, 0));
      @(negedge clk);
    end
    dec_ready = 1'b1;
    for (int i = 0; i < SLOTS; i++) begin
      #1 check_issue(i);
      @(negedge clk);
    end
    // Now at word 1 slot 0, tag 01: stall the bus stream (R8)
    bus_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      #1 check_issue(SLOTS);
      check(bus_valid == 1'b1, "R8", bus_valid, 1);
      @(negedge clk);
    end
    bus_ready = 1'b1;
    #1 check_issue(SLOTS);
    @(negedge clk);
    #1 check_issue(SLOTS + 1);

    // Load offered while running is refused (R10)
    ld_valid = 1'b1; ld_addr = 4'd0; ld_word = '1;
    #1 check(ld_ready == 1'b0, "R10", ld_ready, 0);
    @(negedge clk);
    ld_valid = 1'b0;
    #1 check_issue(SLOTS + 2);
    @(negedge clk);
    run = 1'b0;

    // Out-of-range load: dropped, but the cursor restarts (R10, R11)
    load(14, '1);
    run_issues(0, WORDS * SLOTS);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule